// File: doc/BRIEF.md
# Tick-Based Line Deglitcher

This block cleans up a slow single-wire bus input, such as a consumer-electronics control line, before protocol logic samples it. The raw pin is first brought into the system clock domain by a two-flop synchronizer. A level change then reaches the filtered output only once it has held for a programmable number of ticks. Any excursion that returns to the current output level before that count is reached is dropped.

The ticks come from prescalers inside the block, built on the system clock. A 2-bit select picks one of four time bases: a pulse every three base-clock periods, 1 µs, 10 µs or 100 µs. A 3-bit delay setting `d` sets the acceptance threshold to `3*d` ticks. The usual operating point is the 1 µs base with `d = 7`. A delay of zero switches filtering off, so the synchronized level goes straight to the output.

The select and delay pins are plain control inputs. They are expected to stay static while the line is active. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `line_deglitch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the filtered output is high (the idle line level). This holds whatever level the raw line has.
- R2: With delay 0, a level change on the raw line appears on the output exactly 3 rising clock edges after it is applied. Two of those edges are the synchronizer and one is the output register.
- R3: With delay 0, no filtering takes place: a raw pulse lasting a single clock cycle produces one output pulse, which is two output transitions.
- R4: With delay `d` from 1 to 7 and tick period `T`, a raw excursion of fewer than `(3d-1)*T - 3` clock cycles never changes the output.
- R5: With delay `d` from 1 to 7, a falling edge on the raw line that then holds appears on the output between `3+(3d-1)*T` and `2+3d*T` rising edges after it is applied.
- R6: Tick select encoding sets the tick period `T`:
  - 0: `XTAL_DIV` clocks
  - 1: `US_DIV` clocks
  - 2: `US_DIV*DEC_RATIO` clocks
  - 3: `US_DIV*DEC_RATIO*DEC_RATIO` clocks
- R7: With a nonzero delay, the output changes only on a clock edge where a tick is present, and only to the synchronized input level.
- R8: When the synchronized line returns to the output level, the tick count restarts. A later change therefore again needs the full latency window of R5.
- R9: Rising edges are filtered the same way as falling edges. A short high excursion is dropped, and a held rise appears within the R5 window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_raw | input | 1 | Raw asynchronous line level |
| tick_sel | input | SEL_W (2) | Time base select: 0 base/3, 1 µs, 10 µs, 100 µs |
| dly | input | DLY_W (3) | Acceptance threshold in units of three ticks; 0 bypasses the filter |
| line_filt | output | 1 | Filtered line level |

## Verification
All results are counted in rising edges from the negative edge on which the bench drives the raw line.

- **Delay 0:** the output is due on exactly the third edge. The bench counts edges and samples 1 ns after each one.
- **Nonzero delay:** the prescaler phase is free-running and unknown. The acceptance edge therefore lies in a window one tick period wide, from `3+(3d-1)T` to `2+3dT`, and the bench requires the measured count to fall inside it.
- **Short excursions:** the bench watches the output for a full `3dT+6` cycles after the excursion ends, and fails on any transition seen in that time.

// File: rtl/line_deglitch_pkg.sv
package line_deglitch_pkg;
  // time base encoding on the select pin
  typedef enum logic [1:0] {
    TB_BASE3 = 2'd0,
    TB_1US   = 2'd1,
    TB_10US  = 2'd2,
    TB_100US = 2'd3
  } tbase_e;

  // ticks per delay unit
  localparam int TICKS_PER_UNIT = 3;

  function automatic int cnt_width(input int dly_w);
    return $clog2(TICKS_PER_UNIT * ((1 << dly_w) - 1) + 1);
  endfunction
endpackage

// File: rtl/ldg_sync.sv
module ldg_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ldg_tick_gen.sv
module ldg_tick_gen #(
  parameter int SEL_W     = 2,
  parameter int XTAL_DIV  = 3,
  parameter int US_DIV    = 24,
  parameter int DEC_RATIO = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSRC = 1 << SEL_W;
  localparam int NDEC = NSRC - 2;
  localparam int XW   = $clog2(XTAL_DIV);
  localparam int UW   = $clog2(US_DIV);
  localparam int DW   = $clog2(DEC_RATIO);

  logic [NSRC-1:0] src;

  // base-clock/3 source, free running
  logic [XW-1:0] xcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      xcnt <= '0;
    else if (xcnt == XW'(XTAL_DIV-1)) xcnt <= '0;
    else                             xcnt <= xcnt + XW'(1);
  end
  assign src[0] = (xcnt == XW'(XTAL_DIV-1));

  // microsecond source
  logic [UW-1:0] ucnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ucnt <= '0;
    else if (ucnt == UW'(US_DIV-1)) ucnt <= '0;
    else                            ucnt <= ucnt + UW'(1);
  end
  assign src[1] = (ucnt == UW'(US_DIV-1));

  // decade stages, each counts pulses of the previous stage
  for (genvar g = 0; g < NDEC; g++) begin : g_dec
    logic [DW-1:0] dcnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dcnt <= '0;
      else if (src[g+1]) begin
        if (dcnt == DW'(DEC_RATIO-1)) dcnt <= '0;
        else                          dcnt <= dcnt + DW'(1);
      end
    end
    assign src[g+2] = src[g+1] && (dcnt == DW'(DEC_RATIO-1));
  end

  assign tick = src[sel];
endmodule

// File: rtl/ldg_filter_core.sv
module ldg_filter_core
  import line_deglitch_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly,
  output logic             line_out
);
  localparam int CNT_W = cnt_width(DLY_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_nxt;
  logic             bypass;
  logic             differ;
  logic             reached;

  assign target  = CNT_W'(TICKS_PER_UNIT) * CNT_W'(dly);
  assign bypass  = (dly == '0);
  assign differ  = (line_in != line_out);
  assign cnt_nxt = cnt + CNT_W'(1);
  assign reached = (cnt_nxt >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      line_out <= 1'b1;
    end else if (bypass) begin
      cnt      <= '0;
      line_out <= line_in;
    end else if (!differ) begin
      cnt <= '0;
    end else if (tick) begin
      if (reached) begin
        cnt      <= '0;
        line_out <= line_in;
      end else begin
        cnt <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/line_deglitch.sv
module line_deglitch #(
  parameter int SEL_W     = 2,
  parameter int DLY_W     = 3,
  parameter int XTAL_DIV  = 3,
  parameter int US_DIV    = 24,
  parameter int DEC_RATIO = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_raw,
  input  logic [SEL_W-1:0] tick_sel,
  input  logic [DLY_W-1:0] dly,
  output logic             line_filt
);
  logic line_sync;
  logic tick;

  ldg_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_raw),
    .q     (line_sync)
  );

  ldg_tick_gen #(
    .SEL_W(SEL_W), .XTAL_DIV(XTAL_DIV), .US_DIV(US_DIV), .DEC_RATIO(DEC_RATIO)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (tick_sel),
    .tick  (tick)
  );

  ldg_filter_core #(.DLY_W(DLY_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_sync),
    .tick     (tick),
    .dly      (dly),
    .line_out (line_filt)
  );
endmodule

// File: rtl/line_deglitch_chk.sv
module line_deglitch_chk #(
  parameter int SEL_W = 2,
  parameter int DLY_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_filt,
  input logic             line_sync,
  input logic             tick,
  input logic [SEL_W-1:0] tick_sel,
  input logic [DLY_W-1:0] dly
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> line_filt);

  // R7
  follow_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_filt) |-> (line_filt == $past(line_sync)));

  // R7
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(line_filt) && ($past(dly) != '0)) |-> $past(tick));

  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dly) == '0) |-> (line_filt == $past(line_sync)));

  // R6
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $stable(tick_sel)) |=> (!tick || !$stable(tick_sel)));
endmodule

bind line_deglitch line_deglitch_chk #(.SEL_W(SEL_W), .DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_filt (line_filt),
  .line_sync (line_sync),
  .tick      (tick),
  .tick_sel  (tick_sel),
  .dly       (dly)
);

// File: tb/line_deglitch_tb.sv
module line_deglitch_tb;
  localparam int XD = 3;
  localparam int UD = 4;
  localparam int DR = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_raw = 1'b0;
  logic [1:0] tick_sel = 2'd0;
  logic [2:0] dly = 3'd7;
  logic       line_filt;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  line_deglitch #(.XTAL_DIV(XD), .US_DIV(UD), .DEC_RATIO(DR)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_raw(line_raw),
    .tick_sel(tick_sel), .dly(dly), .line_filt(line_filt)
  );

  function automatic int period(input int s);
    case (s)
      0: return XD;
      1: return UD;
      2: return UD * DR;
      default: return UD * DR * DR;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (sel=%0d dly=%0d)", req, act, exp_v, tick_sel, dly);
    end
  endtask

  // drive level, count rising edges until output follows
  task automatic measure(input bit lvl, input int lo, input int hi, input string req);
    int n = 0;
    @(negedge clk);
    line_raw = lvl;
    while (n <= hi + 10) begin
      @(posedge clk);
      #1;
      n++;
      if (line_filt == lvl) break;
    end
    check(n >= lo && n <= hi, req, n, lo);
  endtask

  // excursion of w cycles away from current level, then watch
  task automatic short_pulse(input bit home, input int w, input int watch, input string req);
    int moves = 0;
    @(negedge clk);
    line_raw = ~home;
    for (int i = 0; i < w; i++) begin
      @(posedge clk); #1;
      if (line_filt != home) moves++;
    end
    @(negedge clk);
    line_raw = home;
    for (int i = 0; i < watch; i++) begin
      @(posedge clk); #1;
      if (line_filt != home) moves++;
    end
    check(moves == 0, req, moves, 0);
  endtask

  task automatic run_cfg(input int s, input int d);
    int t, lo, hi, w, toggles;
    bit prev;
    @(negedge clk);
    line_raw = 1'b1;
    repeat (3 * 7 * period(3) + 10) begin
      @(posedge clk); #1;
      if (line_filt) break;
    end
    @(negedge clk);
    tick_sel = s[1:0];
    dly = d[2:0];
    repeat (3) @(negedge clk);
    t = period(s);
    if (d == 0) begin
      measure(1'b0, 3, 3, "R2");
      measure(1'b1, 3, 3, "R2");
      toggles = 0;
      prev = line_filt;
      @(negedge clk); line_raw = 1'b0;
      @(negedge clk); line_raw = 1'b1;
      repeat (6) begin
        @(posedge clk); #1;
        if (line_filt != prev) toggles++;
        prev = line_filt;
      end
      check(toggles == 2, "R3", toggles, 2);
    end else begin
      lo = 3 + (3 * d - 1) * t;
      hi = 2 + 3 * d * t;
      w = (3 * d - 1) * t - 4;
      if (w < 1) w = 1;
      short_pulse(1'b1, w, 3 * d * t + 6, "R4");
      measure(1'b0, lo, hi, "R5");
      short_pulse(1'b0, w, 3 * d * t + 6, "R9");
      measure(1'b1, lo, hi, "R8");
      short_pulse(1'b1, w, 2, "R4");
      measure(1'b0, lo, hi, "R6");
      measure(1'b1, lo, hi, "R9");
    end
  endtask

  initial begin
    // R1: reset with raw line low
    repeat (3) @(negedge clk);
    check(line_filt == 1'b1, "R1", line_filt, 1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(line_filt == 1'b1, "R1", line_filt, 1);
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 8; d++)
        run_cfg(s, d);
    run_cfg(3, 0);
    run_cfg(3, 1);
    run_cfg(3, 7);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1900000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule